// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous memory that serves four-word bursts. A burst begins when either of two active-low load strobes is sampled low on a rising clock edge. One strobe belongs to a processor and the other to a cache controller. The block then captures the full start address and the ordering mode. Each later edge where the active-low advance input is low moves the two least significant address bits one place along the burst. The upper bits are not touched.

Two orderings exist. Linear ordering counts the low bits upward and wraps modulo four. Interleaved ordering XORs the captured low bits with a step count of 0, 1, 2, 3. A high mode input selects interleaved ordering, and an unconnected pin is taken as high. The address and the burst position come straight from registers, so they are valid one clock after the edge that sampled the inputs. No data flows through the block. Every pin is a plain control or address signal, so there is no valid/ready handshake and no back-pressure.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cur_addr` is all zeros and `burst_pos` is 0.
- R2: When `cpu_strobe_n` is low on an edge, after that edge `cur_addr` equals the `start_addr` sampled on it and `burst_pos` is 0.
- R3: When `cache_strobe_n` is low on an edge, it loads in the same way as R2. If both strobes are low together, a single load takes place.
- R4: With linear ordering captured (`order_sel` = 0 at load), each advance edge sets `cur_addr[1:0]` to its previous value plus one, modulo 4.
- R5: With interleaved ordering captured (`order_sel` = 1 at load), `cur_addr[1:0]` always equals the loaded low bits XOR `burst_pos`. For example, a start of 1 gives 1, 0, 3, 2.
- R6: On every edge without a load, `cur_addr[ADDR_W-1:2]` is unchanged.
- R7: On an edge where both strobes and `adv_n` are high, `cur_addr` and `burst_pos` keep their values.
- R8: A strobe on the same edge as `adv_n` low takes priority. The address is reloaded and `burst_pos` returns to 0, so any burst in progress is cancelled.
- R9: `burst_pos` rises by one on each advance edge and wraps from 3 to 0. After four advances the address is back at the start address.
- R10: `order_sel` is sampled only on load edges. Changing it during a burst does not alter the ordering of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_strobe_n | input | 1 | Active-low load strobe from the processor |
| cache_strobe_n | input | 1 | Active-low load strobe from the cache controller |
| adv_n | input | 1 | Active-low advance to the next burst position |
| order_sel | input | 1 | Burst ordering: 0 linear, 1 interleaved (tie high when unused) |
| start_addr | input | ADDR_W | Address captured on a load |
| cur_addr | output | ADDR_W | Current word address |
| burst_pos | output | 2 | Position within the burst, 0 to 3 |

## Verification
Two functions can be requested on the same edge: a load from either strobe, and an advance. The bench provokes this by holding `adv_n` low on edges where a strobe is also low, both partway through a running burst and at its very start. On the next cycle the address must equal the newly sampled start address and the position must be 0, with no advance applied. A second, milder overlap is a mode change during an advance. This is judged by requiring the ordering captured at load to persist.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned STEP_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  advance,
  output step_t step
);
  step_t step_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       step_q <= '0;
    else if (clear)   step_q <= '0;
    else if (advance) step_q <= step_q + step_t'(1);
  end

  assign step = step_q;

  // R9: position wraps from the top back to zero
  p_step_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && advance && step_q == '1) |=> (step_q == '0));

  // R8: clear wins over advance
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && advance) |=> (step_q == '0));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        load_addr,
  input  logic                     mode_in,
  output logic [ADDR_W-STEP_W-1:0] upper_q,
  output step_t                    base_q,
  output burst_order_e             mode_q
);
  localparam int unsigned UPPER_W = ADDR_W - STEP_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      mode_q  <= ORDER_LINEAR;
    end else if (load) begin
      upper_q <= load_addr[ADDR_W-1:STEP_W];
      base_q  <= load_addr[STEP_W-1:0];
      mode_q  <= burst_order_e'(mode_in);
    end
  end

  // R6: upper bits fixed between loads
  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(upper_q));

  // R10: mode only follows the pin on load edges
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode_q));

  initial begin
    assert (UPPER_W >= 1);
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  step_t        base,
  input  step_t        step,
  input  burst_order_e mode,
  output step_t        low
);
  always_comb begin
    unique case (mode)
      ORDER_XOR: low = base ^ step;
      default:   low = base + step;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strobe_n,
  input  logic              cache_strobe_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        burst_pos
);
  localparam int unsigned UPPER_W = ADDR_W - STEP_W;

  logic               load;
  logic               advance;
  logic [UPPER_W-1:0] upper_q;
  step_t              base_q;
  step_t              step_q;
  step_t              low;
  burst_order_e       mode_q;

  assign load    = !cpu_strobe_n || !cache_strobe_n;
  assign advance = !adv_n;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (start_addr),
    .mode_in   (order_sel),
    .upper_q   (upper_q),
    .base_q    (base_q),
    .mode_q    (mode_q)
  );

  burst_step_ctr u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .advance (advance),
    .step    (step_q)
  );

  burst_order_map u_map (
    .base (base_q),
    .step (step_q),
    .mode (mode_q),
    .low  (low)
  );

  assign cur_addr  = {upper_q, low};
  assign burst_pos = step_q;

  // R2 / R3: either strobe loads the sampled address
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_strobe_n |=> (cur_addr == $past(start_addr) && burst_pos == 2'd0));
  p_load_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_strobe_n |=> (cur_addr == $past(start_addr) && burst_pos == 2'd0));

  // R4: linear step adds one to the low bits
  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && mode_q == ORDER_LINEAR)
      |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  // R5: interleaved low bits track base XOR position
  p_xor_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ORDER_XOR) |-> ((cur_addr[1:0] ^ base_q) == burst_pos));

  // R7: idle edges hold the output
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> ($stable(cur_addr) && $stable(burst_pos)));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int ADDR_W = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_strobe_n = 1'b1;
  logic cache_strobe_n = 1'b1;
  logic adv_n = 1'b1;
  logic order_sel = 1'b1;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        burst_pos;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [ADDR_W-1:0] m_start = '0;
  int m_step = 0;
  int m_mode = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n),
    .cache_strobe_n(cache_strobe_n), .adv_n(adv_n), .order_sel(order_sel),
    .start_addr(start_addr), .cur_addr(cur_addr), .burst_pos(burst_pos)
  );

  task automatic check(input string tag, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] model_addr();
    int lo;
    int b;
    b = int'(m_start[1:0]);
    if (m_mode != 0) lo = b ^ m_step;
    else             lo = (b + m_step) % 4;
    return {m_start[ADDR_W-1:2], 2'(lo)};
  endfunction

  // one edge: drive at negedge, sample at the following negedge
  task automatic cycle(input logic cpu_n, input logic cache_n, input logic a_n,
                       input logic mode, input logic [ADDR_W-1:0] addr);
    string tag;
    logic [ADDR_W-1:0] prev_upper;
    bit load;
    load = !cpu_n || !cache_n;
    cpu_strobe_n = cpu_n; cache_strobe_n = cache_n; adv_n = a_n;
    order_sel = mode; start_addr = addr;
    if (load)                  tag = !a_n ? "R8" : (!cpu_n ? "R2" : "R3");
    else if (int'(mode) != m_mode) tag = "R10";
    else if (!a_n)             tag = (m_step == 3) ? "R9" : (m_mode != 0 ? "R5" : "R4");
    else                       tag = "R7";
    prev_upper = {2'b00, cur_addr[ADDR_W-1:2]};
    @(posedge clk);
    if (load) begin
      m_start = addr; m_step = 0; m_mode = int'(mode);
    end else if (!a_n) begin
      m_step = (m_step + 1) % 4;
    end
    @(negedge clk);
    check(tag, cur_addr, model_addr());
    check(tag, {{(ADDR_W-2){1'b0}}, burst_pos}, ADDR_W'(m_step));
    if (!load) check("R6", {2'b00, cur_addr[ADDR_W-1:2]}, prev_upper);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", cur_addr, '0);
    check("R1", {{(ADDR_W-2){1'b0}}, burst_pos}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", cur_addr, '0);

    // sweep: start low bits x ordering x strobe source
    for (int s = 0; s < 4; s++) begin
      for (int md = 0; md < 2; md++) begin
        for (int src = 0; src < 2; src++) begin
          logic [ADDR_W-1:0] a;
          a = ADDR_W'((s * 1237 + md * 311 + src * 97 + 5) << 2) | ADDR_W'(s);
          cycle(src != 0, src == 0, 1'b1, md[0], a);
          cycle(1'b1, 1'b1, 1'b0, md[0], '1);
          cycle(1'b1, 1'b1, 1'b0, md[0], '0);
          cycle(1'b1, 1'b1, 1'b1, md[0], '1);
          cycle(1'b1, 1'b1, 1'b0, ~md[0], '0);
          cycle(1'b1, 1'b1, 1'b0, md[0], '1);
          cycle(1'b1, 1'b1, 1'b0, ~md[0], '0);
          cycle(1'b1, 1'b1, 1'b1, ~md[0], '0);
        end
      end
    end

    // strobe and advance on the same edge, mid burst and back to back
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 17'h1_2342);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 17'h0_ABC1);
    cycle(1'b1, 1'b1, 1'b0, 1'b1, '0);
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 17'h1_FFF3);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 17'h0_0002);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
    cycle(1'b1, 1'b1, 1'b1, 1'b1, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule